// File: doc/BRIEF.md
# Memory Error Capture Registers

This block sits beside a DRAM controller's ECC checker and keeps a record of corrected (single-bit) and uncorrectable (multi-bit) error events until software reads and acknowledges them. Each error class arrives as a one-cycle pulse with its own failing physical address and memory row number. The block stores the 4 KB page of the failing address, one occurrence flag per class, and the row of the first error in each class. A command register selects which error classes drive a system-error level output.

Software reaches the block through a small register port with one-cycle registered reads. Flags are cleared by writing 1 to them. While a flag is set, later errors of that class leave the captured information alone, so the first event is never lost to a burst.

Top module: `mem_err_capture`

## Requirements
- R1: After a synchronous reset, all flags, row fields, the captured page, the enables, `serr_o`, `reg_rdata_o` and `reg_rvalid_o` are zero.
- R2: Register index 0 (address register) reads the captured page in bits 31:12, the address single-bit flag in bit 0 and the address multi-bit flag in bit 1; bits 11:2 read zero.
- R3: A single-bit pulse sets address bit 0 and status bit 0; if status bit 0 was clear, the row is stored in status bits 3:1.
- R4: A multi-bit pulse sets address bit 1 and status bit 4; if status bit 4 was clear, the row is stored in status bits 7:5. Status bits 31:8 read zero.
- R5: While a status flag is set and not being cleared, further pulses of that class leave its row field unchanged.
- R6: The page is loaded from the multi-bit address when a multi-bit pulse arrives with address bit 1 clear; it is loaded from the single-bit address only when a single-bit pulse arrives with both address flags clear and no multi-bit capture in that cycle. Both pulses in one cycle load the multi-bit address.
- R7: Writing 1 to address bit 0 or 1 clears that address flag only; writing 1 to status bit 0 or 4 clears that status flag and zeroes its row field. Writing 0, writing any other bit, or writing the page bits changes nothing.
- R8: A clear and a pulse of the same class in the same cycle leave the flag set and capture the new row (and page, per R6).
- R9: Register index 2 (command) holds two read/write enable bits, bit 0 for single-bit and bit 1 for multi-bit; bits 31:2 read zero.
- R10: `serr_o` is high exactly when (status bit 0 and enable bit 0) or (status bit 4 and enable bit 1), aligned with the register state after each clock edge.
- R11: A read request returns data and `reg_rvalid_o` one cycle later, showing the state before that edge; index 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbe_i | input | 1 | Single-bit error pulse |
| sbe_addr_i | input | 32 | Failing address of the single-bit error |
| sbe_row_i | input | 3 | Memory row of the single-bit error |
| mbe_i | input | 1 | Multi-bit error pulse |
| mbe_addr_i | input | 32 | Failing address of the multi-bit error |
| mbe_row_i | input | 3 | Memory row of the multi-bit error |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_idx_i | input | 2 | Register index: 0 address, 1 status, 2 command, 3 unused |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after the request |
| serr_o | output | 1 | System-error level |

## Verification
Assertions watch, on every cycle, that a held status flag keeps its row, that a pending multi-bit address is never overwritten, that a pulse always leaves its flag set even with a concurrent clear, that command writes land, and the read handshake timing. Only the bench scenarios show the full register layouts, the address priority between classes, the independence of address and status flags, the ignored write bits and every enable and flag combination on the system-error output, by sweeping all eight rows in both classes against an arithmetic model.

// File: rtl/mem_err_pkg.sv
package mem_err_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    IDX_ADDR = 2'd0,
    IDX_STAT = 2'd1,
    IDX_CMD  = 2'd2,
    IDX_RSVD = 2'd3
  } reg_idx_e;

  localparam int NUM_CLASS = 2;
  localparam int CLS_SINGLE = 0;
  localparam int CLS_MULTI = 1;
endpackage

// File: rtl/mec_flag_field.sv
module mec_flag_field #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_i,
  input  logic [FW-1:0] field_i,
  input  logic          clr_i,
  output logic          flag_q_o,
  output logic          flag_d_o,
  output logic [FW-1:0] field_q_o
);
  logic          flag_q;
  logic [FW-1:0] field_q;
  logic          flag_eff;
  logic          take;
  logic [FW-1:0] field_d;

  assign flag_eff = flag_q & ~clr_i;
  assign take     = evt_i & ~flag_eff;
  assign flag_d_o = flag_eff | evt_i;

  always_comb begin
    field_d = field_q;
    if (take)       field_d = field_i;
    else if (clr_i) field_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      field_q <= '0;
    end else begin
      flag_q  <= flag_d_o;
      field_q <= field_d;
    end
  end

  assign flag_q_o  = flag_q;
  assign field_q_o = field_q;

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> (flag_q && $stable(field_q)));

  assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> flag_q);
endmodule

// File: rtl/mec_addr_reg.sv
module mec_addr_reg #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sbe_i,
  input  logic [ADDR_W-1:0]          sbe_addr_i,
  input  logic                       mbe_i,
  input  logic [ADDR_W-1:0]          mbe_addr_i,
  input  logic                       clr_s_i,
  input  logic                       clr_m_i,
  output logic                       sf_q_o,
  output logic                       mf_q_o,
  output logic [ADDR_W-PAGE_LSB-1:0] page_q_o
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  logic              sf_q, mf_q;
  logic [PAGE_W-1:0] page_q;
  logic              s_eff, m_eff;
  logic              take_m, take_s;
  logic [PAGE_W-1:0] page_d;
  logic [PAGE_LSB-1:0] low_unused;

  assign low_unused = sbe_addr_i[PAGE_LSB-1:0] ^ mbe_addr_i[PAGE_LSB-1:0];

  assign s_eff  = sf_q & ~clr_s_i;
  assign m_eff  = mf_q & ~clr_m_i;
  assign take_m = mbe_i & ~m_eff;
  assign take_s = sbe_i & ~s_eff & ~m_eff;

  always_comb begin
    page_d = page_q;
    if (take_m)      page_d = mbe_addr_i[ADDR_W-1:PAGE_LSB];
    else if (take_s) page_d = sbe_addr_i[ADDR_W-1:PAGE_LSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sf_q   <= 1'b0;
      mf_q   <= 1'b0;
      page_q <= '0;
    end else begin
      sf_q   <= s_eff | sbe_i;
      mf_q   <= m_eff | mbe_i;
      page_q <= page_d;
    end
  end

  assign sf_q_o   = sf_q;
  assign mf_q_o   = mf_q;
  assign page_q_o = page_q;

  assert_page_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mf_q && !clr_m_i) |=> $stable(page_q));

  assert_multi_flag_R4: assert property (@(posedge clk) disable iff (rst)
    mbe_i |=> mf_q);
endmodule

// File: rtl/mec_reg_port.sv
module mec_reg_port
  import mem_err_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ROW_W    = 3,
  parameter int PAGE_LSB = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_i,
  input  logic                         rd_i,
  input  logic [REG_AW-1:0]            idx_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic                         addr_sf_i,
  input  logic                         addr_mf_i,
  input  logic [DATA_W-PAGE_LSB-1:0]   page_i,
  input  logic [NUM_CLASS-1:0]         stat_flag_i,
  input  logic [NUM_CLASS*ROW_W-1:0]   stat_row_i,
  output logic [NUM_CLASS-1:0]         clr_addr_o,
  output logic [NUM_CLASS-1:0]         clr_stat_o,
  output logic [NUM_CLASS-1:0]         en_q_o,
  output logic [NUM_CLASS-1:0]         en_d_o,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         rvalid_o
);
  localparam int FLD    = ROW_W + 1;
  localparam int PAGE_W = DATA_W - PAGE_LSB;

  reg_idx_e                idx;
  logic [NUM_CLASS-1:0]    en_q;
  logic [DATA_W-1:0]       addr_word, stat_word, cmd_word, rd_mux;
  logic [DATA_W-1:0]       rdata_q;
  logic                    rvalid_q;
  logic [DATA_W-1:0]       wdata_unused;

  assign idx          = reg_idx_e'(idx_i);
  assign wdata_unused = wdata_i;

  assign clr_addr_o[CLS_SINGLE] = wr_i && (idx == IDX_ADDR) && wdata_i[0];
  assign clr_addr_o[CLS_MULTI]  = wr_i && (idx == IDX_ADDR) && wdata_i[1];

  genvar c;
  generate
    for (c = 0; c < NUM_CLASS; c++) begin : g_stat_clr
      assign clr_stat_o[c] = wr_i && (idx == IDX_STAT) && wdata_i[c*FLD];
    end
  endgenerate

  assign en_d_o = (wr_i && (idx == IDX_CMD)) ? wdata_i[NUM_CLASS-1:0] : en_q;

  always_comb begin
    addr_word = '0;
    addr_word[DATA_W-1 -: PAGE_W] = page_i;
    addr_word[1] = addr_mf_i;
    addr_word[0] = addr_sf_i;
  end

  always_comb begin
    stat_word = '0;
    for (int k = 0; k < NUM_CLASS; k++) begin
      stat_word[k*FLD]          = stat_flag_i[k];
      stat_word[k*FLD+1 +: ROW_W] = stat_row_i[k*ROW_W +: ROW_W];
    end
  end

  always_comb begin
    cmd_word = '0;
    cmd_word[NUM_CLASS-1:0] = en_q;
  end

  always_comb begin
    unique case (idx)
      IDX_ADDR: rd_mux = addr_word;
      IDX_STAT: rd_mux = stat_word;
      IDX_CMD:  rd_mux = cmd_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      en_q     <= en_d_o;
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rd_mux;
    end
  end

  assign en_q_o   = en_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  assert_cmd_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_i && idx == IDX_CMD) |=> (en_q == $past(wdata_i[NUM_CLASS-1:0])));

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> rvalid_o);

  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_i && idx == IDX_RSVD) |=> (rdata_o == '0));
endmodule

// File: rtl/mem_err_capture.sv
module mem_err_capture
  import mem_err_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ROW_W    = 3,
  parameter int PAGE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_i,
  input  logic [ADDR_W-1:0] sbe_addr_i,
  input  logic [ROW_W-1:0]  sbe_row_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] mbe_addr_i,
  input  logic [ROW_W-1:0]  mbe_row_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_idx_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              serr_o
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  logic [NUM_CLASS-1:0]       evt;
  logic [NUM_CLASS*ROW_W-1:0] row_in;
  logic [NUM_CLASS-1:0]       stat_flag_q, stat_flag_d;
  logic [NUM_CLASS*ROW_W-1:0] stat_row_q;
  logic [NUM_CLASS-1:0]       clr_addr, clr_stat, en_q, en_d;
  logic                       addr_sf, addr_mf;
  logic [PAGE_W-1:0]          page_q;
  logic                       serr_q;

  assign evt    = {mbe_i, sbe_i};
  assign row_in = {mbe_row_i, sbe_row_i};

  genvar c;
  generate
    for (c = 0; c < NUM_CLASS; c++) begin : g_cls
      mec_flag_field #(.FW(ROW_W)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt[c]),
        .field_i  (row_in[c*ROW_W +: ROW_W]),
        .clr_i    (clr_stat[c]),
        .flag_q_o (stat_flag_q[c]),
        .flag_d_o (stat_flag_d[c]),
        .field_q_o(stat_row_q[c*ROW_W +: ROW_W])
      );
    end
  endgenerate

  mec_addr_reg #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .sbe_i     (sbe_i),
    .sbe_addr_i(sbe_addr_i),
    .mbe_i     (mbe_i),
    .mbe_addr_i(mbe_addr_i),
    .clr_s_i   (clr_addr[CLS_SINGLE]),
    .clr_m_i   (clr_addr[CLS_MULTI]),
    .sf_q_o    (addr_sf),
    .mf_q_o    (addr_mf),
    .page_q_o  (page_q)
  );

  mec_reg_port #(.DATA_W(ADDR_W), .ROW_W(ROW_W), .PAGE_LSB(PAGE_LSB)) u_port (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .idx_i      (reg_idx_i),
    .wdata_i    (reg_wdata_i),
    .addr_sf_i  (addr_sf),
    .addr_mf_i  (addr_mf),
    .page_i     (page_q),
    .stat_flag_i(stat_flag_q),
    .stat_row_i (stat_row_q),
    .clr_addr_o (clr_addr),
    .clr_stat_o (clr_stat),
    .en_q_o     (en_q),
    .en_d_o     (en_d),
    .rdata_o    (reg_rdata_o),
    .rvalid_o   (reg_rvalid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) serr_q <= 1'b0;
    else     serr_q <= |(stat_flag_d & en_d);
  end

  assign serr_o = serr_q;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!serr_o && !reg_rvalid_o && stat_flag_q == '0 && en_q == '0));

  assert_serr_source_R10: assert property (@(posedge clk) disable iff (rst)
    serr_o |-> (stat_flag_q != '0));
endmodule

// File: tb/mem_err_capture_tb_top.sv
module mem_err_capture_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sbe_i = 1'b0, mbe_i = 1'b0;
  logic [31:0] sbe_addr_i = '0, mbe_addr_i = '0;
  logic [2:0]  sbe_row_i = '0, mbe_row_i = '0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [1:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        reg_rvalid_o, serr_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic        m_asf, m_amf, m_sf, m_mf;
  logic [19:0] m_page;
  logic [2:0]  m_srow, m_mrow;
  logic [1:0]  m_en;

  always #(CLK_P/2) clk = ~clk;

  mem_err_capture dut_i (
    .clk(clk), .rst(rst),
    .sbe_i(sbe_i), .sbe_addr_i(sbe_addr_i), .sbe_row_i(sbe_row_i),
    .mbe_i(mbe_i), .mbe_addr_i(mbe_addr_i), .mbe_row_i(mbe_row_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_idx_i(reg_idx_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .reg_rvalid_o(reg_rvalid_o), .serr_o(serr_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int k);
    return (32'h9E37_79B9 * (k + 1)) ^ 32'h0000_0ABC;
  endfunction

  // One clock with the given stimulus; model follows the requirements.
  task automatic cyc(input logic s, input logic [31:0] sa, input logic [2:0] sr,
                     input logic m, input logic [31:0] ma, input logic [2:0] mr,
                     input logic wr, input logic [1:0] idx, input logic [31:0] wd);
    logic ca_s, ca_m, cs_s, cs_m, as_e, am_e, ss_e, ms_e;
    sbe_i = s; sbe_addr_i = sa; sbe_row_i = sr;
    mbe_i = m; mbe_addr_i = ma; mbe_row_i = mr;
    reg_wr_i = wr; reg_idx_i = idx; reg_wdata_i = wd;
    ca_s = wr && idx == 2'd0 && wd[0];
    ca_m = wr && idx == 2'd0 && wd[1];
    cs_s = wr && idx == 2'd1 && wd[0];
    cs_m = wr && idx == 2'd1 && wd[4];
    as_e = m_asf & ~ca_s; am_e = m_amf & ~ca_m;
    ss_e = m_sf & ~cs_s;  ms_e = m_mf & ~cs_m;
    @(posedge clk);
    if (m && !am_e) m_page = ma[31:12];
    else if (s && !as_e && !am_e) m_page = sa[31:12];
    m_asf = as_e | s; m_amf = am_e | m;
    if (s && !ss_e) m_srow = sr; else if (cs_s) m_srow = '0;
    if (m && !ms_e) m_mrow = mr; else if (cs_m) m_mrow = '0;
    m_sf = ss_e | s; m_mf = ms_e | m;
    if (wr && idx == 2'd2) m_en = wd[1:0];
    @(negedge clk);
    sbe_i = 1'b0; mbe_i = 1'b0; reg_wr_i = 1'b0;
    chk("R10 serr", {31'b0, serr_o}, {31'b0, (m_sf & m_en[0]) | (m_mf & m_en[1])});
  endtask

  task automatic rd(input string req, input logic [1:0] idx, input logic [31:0] exp);
    reg_rd_i = 1'b1; reg_idx_i = idx;
    @(posedge clk);
    @(negedge clk);
    reg_rd_i = 1'b0;
    chk("R11 rvalid", {31'b0, reg_rvalid_o}, 32'd1);
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic rd_all(input string tag);
    rd({"R2 addr ", tag}, 2'd0, {m_page, 10'b0, m_amf, m_asf});
    rd({"R3/R4 stat ", tag}, 2'd1, {24'b0, m_mrow, m_mf, m_srow, m_sf});
    rd({"R9 cmd ", tag}, 2'd2, {30'b0, m_en});
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    m_asf = 0; m_amf = 0; m_sf = 0; m_mf = 0; m_page = 0;
    m_srow = 0; m_mrow = 0; m_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 serr", {31'b0, serr_o}, 32'd0);
    chk("R1 rvalid", {31'b0, reg_rvalid_o}, 32'd0);
    chk("R1 rdata", reg_rdata_o, 32'd0);
    rd("R1 addr", 2'd0, 32'd0);
    rd("R1 stat", 2'd1, 32'd0);
    rd("R1 cmd", 2'd2, 32'd0);

    // R9: command enables, upper bits ignored
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF);
    rd("R9 cmd all", 2'd2, 32'd3);

    // R3, R5, R7: single-bit sweep over all rows
    for (int r = 0; r < 8; r++) begin
      cyc(1, mk_addr(r), 3'(r), 0, 0, 0, 0, 0, 0);
      rd_all("R3 first");
      cyc(1, mk_addr(r + 40), 3'(7 - r), 0, 0, 0, 0, 0, 0);
      rd_all("R5 held");
      cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0001);
      rd_all("R7 addr clr only");
      cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_0001);
      rd_all("R7 stat clr");
    end

    // R4, R5: multi-bit sweep over all rows
    for (int r = 0; r < 8; r++) begin
      cyc(0, 0, 0, 1, mk_addr(r + 8), 3'(r), 0, 0, 0);
      rd_all("R4 first");
      cyc(0, 0, 0, 1, mk_addr(r + 60), 3'(r ^ 5), 0, 0, 0);
      rd_all("R5 held");
      cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_0010);
      cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0002);
      rd_all("R7 clr multi");
    end

    // R6: simultaneous arrival, multi-bit address wins
    cyc(1, mk_addr(100), 3'd2, 1, mk_addr(101), 3'd6, 0, 0, 0);
    rd_all("R6 both");
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0003);
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_0011);
    // R6: single captured, then multi overwrites page
    cyc(1, mk_addr(110), 3'd1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, mk_addr(111), 3'd3, 0, 0, 0);
    rd_all("R6 multi over single");
    // R6: multi pending, single flag cleared, new single cannot move page
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0001);
    cyc(1, mk_addr(112), 3'd4, 0, 0, 0, 0, 0, 0);
    rd_all("R6 multi pending");

    // R7: zero writes and page-bit writes do nothing
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'hFFFF_F000);
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'hFFFF_FFEE);
    rd_all("R7 ignored bits");
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0003);
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_0011);

    // R8: clear and new event in the same cycle
    cyc(1, mk_addr(120), 3'd5, 1, mk_addr(121), 3'd1, 0, 0, 0);
    cyc(1, mk_addr(122), 3'd7, 0, 0, 0, 1, 2'd1, 32'h0000_0001);
    rd_all("R8 stat clr+evt");
    cyc(0, 0, 0, 1, mk_addr(123), 3'd2, 1, 2'd0, 32'h0000_0002);
    rd_all("R8 addr clr+evt");
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0003);
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_0011);

    // R10: every enable against every status flag combination
    for (int e = 0; e < 4; e++) begin
      for (int f = 0; f < 4; f++) begin
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd2, 32'(e));
        cyc(f[0], mk_addr(f), 3'(f), f[1], mk_addr(f + 4), 3'(e), 0, 0, 0);
        idle();
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_0011);
        cyc(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0003);
      end
    end

    // R11: unused index reads zero, no read means no valid
    rd("R11 rsvd", 2'd3, 32'd0);
    idle();
    chk("R11 rvalid low", {31'b0, reg_rvalid_o}, 32'd0);

    // R1: reset mid-operation
    cyc(1, mk_addr(200), 3'd3, 1, mk_addr(201), 3'd4, 0, 0, 0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_asf = 0; m_amf = 0; m_sf = 0; m_mf = 0; m_page = 0;
    m_srow = 0; m_mrow = 0; m_en = 0;
    chk("R1 serr after reset", {31'b0, serr_o}, 32'd0);
    rd_all("R1 after reset");

    finish_up();
  end
endmodule